// File: doc/BRIEF.md
# Load/Store Address and Extend Unit

This block turns one immediate-offset load or store request into memory traffic. It takes a base address, an unsigned immediate with an add/subtract flag, an addressing mode, an access size, a signedness flag, a direction flag and a two-word flag. From these it computes the access address and the updated base value. It drives a synchronous single-port memory for one beat, or for two consecutive beats in a two-word transfer. It returns the load data, right-aligned and extended, together with a base write-back strobe.

A request is presented for one cycle with `start` while `busy` is low. All operands are captured on that edge. The memory request appears in the following cycle. Read data is expected in the cycle after the memory samples a read request. Load results and the write-back strobe are registered outputs.

Top module: `ldst_unit`

## Requirements
- R1: The updated address is `base + offset` when `sub` is 0 and `base - offset` when `sub` is 1, modulo 2^ADDR_W. A zero offset leaves the address equal to `base`.
- R2: Mode 0 (plain offset) accesses the updated address and never raises `wb_en`.
- R3: Mode 1 (pre-index) accesses the updated address and writes the updated address back (`wb_en`=1, `wb_val`=updated address).
- R4: Mode 2 (post-index) accesses the unmodified base and writes back base ± offset.
- R5: The byte enables depend on the access size. For size 0 (byte), only bit `addr[1:0]` is set. For size 1 (halfword), the enable is `4'b0011` when `addr[1]`=0 and `4'b1100` when `addr[1]`=1. For size 2 (word) and for every two-word beat, the enable is `4'b1111`.
- R6: Store data is copied into every byte lane for a byte store and into both halves for a halfword store. A word store passes the data through unchanged.
- R7: Load data is taken from the selected byte or halfword lane and right-aligned. It is zero-extended when `sign`=0 and sign-extended from bit 7 or bit 15 when `sign`=1. A word load is returned unchanged.
- R8: A request is illegal in three cases: mode 3; size 3 without `dual`; `sign`=1 on a byte or halfword store. An illegal request pulses `illegal` for one cycle, the cycle after `start`. It issues no memory request, does not set `busy` and raises no `wb_en`.
- R9: With `dual`=1, two word beats are issued on consecutive cycles. The first goes to the access address with `st_data` and the second to the access address + 4 with `st_data2`. A two-word load returns two results: the first with `ld_second`=0 and the next cycle with `ld_second`=1.
- R10: Timing, with `start` accepted at edge k. The memory request is visible after edge k. A single-beat transfer returns its result after edge k+2, and a two-word transfer returns its results after edges k+2 and k+3. `wb_en` pulses exactly once, together with the final result slot, and `busy` is low from that cycle on.
- R11: A `start` presented while `busy` is high is ignored, and the in-flight transfer is not altered.
- R12: After reset, `busy`, `illegal`, `mem_req`, `ld_valid` and `wb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| base | input | ADDR_W | Base register value |
| offset | input | OFF_W | Unsigned immediate |
| sub | input | 1 | 1 subtracts the immediate |
| mode | input | 2 | 0 offset, 1 pre-index, 2 post-index, 3 illegal |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| sign | input | 1 | Sign-extend loads of byte or halfword |
| is_store | input | 1 | 1 store, 0 load |
| dual | input | 1 | Two-word transfer |
| st_data | input | 32 | Store data, first register |
| st_data2 | input | 32 | Store data, second register |
| busy | output | 1 | Transfer in flight |
| illegal | output | 1 | One-cycle pulse for a rejected request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| ld_valid | output | 1 | Load result strobe |
| ld_second | output | 1 | Result belongs to the second register |
| ld_data | output | 32 | Extended load result |
| wb_en | output | 1 | Base write-back strobe |
| wb_val | output | ADDR_W | Base write-back value |

## Verification
The bench builds the unit with ADDR_W=16 and OFF_W=8. The narrow address makes wrap-around reachable with short stimuli: adding past 0xFFFF and subtracting below zero both exercise the modulo rule of R1. The narrow immediate also exercises the zero-padding path of the adder. A 64-word memory model in the bench covers every lane and both halves. Stores followed by sign and zero-extended loads therefore reach every byte enable and extension case.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2,
        AM_BAD    = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } asize_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BEAT0 = 2'd1,
        PH_BEAT1 = 2'd2,
        PH_FIN   = 2'd3
    } phase_e;
endpackage

// File: rtl/ldst_agen.sv
module ldst_agen #(
    parameter int AW = 32,
    parameter int OW = 12
) (
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] off_i,
    input  logic          sub_i,
    input  logic          post_i,
    output logic [AW-1:0] acc_o,
    output logic [AW-1:0] upd_o
);
    logic [AW-1:0] off_ext;

    generate
        if (OW >= AW) begin : g_trunc
            assign off_ext = off_i[AW-1:0];
        end else begin : g_pad
            localparam int PADW = AW - OW;
            assign off_ext = {{PADW{1'b0}}, off_i};
        end
    endgenerate

    always_comb begin
        upd_o = sub_i ? (base_i - off_ext) : (base_i + off_ext);
        acc_o = post_i ? base_i : upd_o;
    end
endmodule

// File: rtl/ldst_lanes.sv
module ldst_lanes
    import ldst_pkg::*;
(
    input  logic [1:0]        alo_i,
    input  asize_e            sz_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [LANES-1:0]  be_o,
    output logic [WORD_W-1:0] wdata_o
);
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam logic [1:0] LID = 2'(i);
            localparam int HSEL = i % 2;
            assign be_o[i] = (sz_i == SZ_BYTE) ? (alo_i == LID) :
                             (sz_i == SZ_HALF) ? (alo_i[1] == LID[1]) : 1'b1;
            assign wdata_o[8*i +: 8] = (sz_i == SZ_BYTE) ? data_i[7:0] :
                                       (sz_i == SZ_HALF) ? data_i[8*HSEL +: 8] :
                                                           data_i[8*i +: 8];
        end
    endgenerate
endmodule

// File: rtl/ldst_extend.sv
module ldst_extend
    import ldst_pkg::*;
(
    input  logic [WORD_W-1:0] rdata_i,
    input  logic [1:0]        alo_i,
    input  asize_e            sz_i,
    input  logic              sign_i,
    output logic [WORD_W-1:0] res_o
);
    logic [WORD_W-1:0] byte_sh;
    logic [WORD_W-1:0] half_sh;

    always_comb begin
        byte_sh = rdata_i >> {alo_i, 3'b000};
        half_sh = rdata_i >> {alo_i[1], 4'b0000};
        unique case (sz_i)
            SZ_BYTE: res_o = {{(WORD_W-8){sign_i & byte_sh[7]}}, byte_sh[7:0]};
            SZ_HALF: res_o = {{(WORD_W-16){sign_i & half_sh[15]}}, half_sh[15:0]};
            default: res_o = rdata_i;
        endcase
    end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              sub,
    input  logic [1:0]        mode,
    input  logic [1:0]        size,
    input  logic              sign,
    input  logic              is_store,
    input  logic              dual,
    input  logic [31:0]       st_data,
    input  logic [31:0]       st_data2,
    output logic              busy,
    output logic              illegal,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              ld_valid,
    output logic              ld_second,
    output logic [31:0]       ld_data,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_val
);
    localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(LANES);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] acc;
        logic [ADDR_W-1:0] upd;
        logic              do_wb;
        asize_e            sz;
        logic              sgn;
        logic              st;
        logic              du;
        logic [WORD_W-1:0] d0;
        logic [WORD_W-1:0] d1;
        logic              bad;
        logic              rv;
        logic              r2;
        logic [WORD_W-1:0] res;
        logic              wbe;
    } state_t;

    state_t s_d, s_q;

    amode_e            mode_in;
    asize_e            size_in;
    logic              req_bad;
    logic [ADDR_W-1:0] acc_new;
    logic [ADDR_W-1:0] upd_new;
    logic [WORD_W-1:0] beat_data;
    logic [WORD_W-1:0] ext_res;

    assign mode_in = amode_e'(mode);
    assign size_in = asize_e'(size);

    ldst_agen #(.AW(ADDR_W), .OW(OFF_W)) u_agen (
        .base_i (base),
        .off_i  (offset),
        .sub_i  (sub),
        .post_i (mode_in == AM_POST),
        .acc_o  (acc_new),
        .upd_o  (upd_new)
    );

    assign beat_data = (s_q.ph == PH_BEAT1) ? s_q.d1 : s_q.d0;

    ldst_lanes u_lanes (
        .alo_i   (s_q.acc[1:0]),
        .sz_i    (s_q.sz),
        .data_i  (beat_data),
        .be_o    (mem_be),
        .wdata_o (mem_wdata)
    );

    ldst_extend u_ext (
        .rdata_i (mem_rdata),
        .alo_i   (s_q.acc[1:0]),
        .sz_i    (s_q.sz),
        .sign_i  (s_q.sgn),
        .res_o   (ext_res)
    );

    always_comb begin
        req_bad = (mode_in == AM_BAD) ||
                  (!dual && (size_in == SZ_BAD)) ||
                  (!dual && sign && is_store && (size_in != SZ_WORD));
    end

    always_comb begin
        s_d     = s_q;
        s_d.bad = 1'b0;
        s_d.rv  = 1'b0;
        s_d.r2  = 1'b0;
        s_d.wbe = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (req_bad) begin
                        s_d.bad = 1'b1;
                    end else begin
                        s_d.ph    = PH_BEAT0;
                        s_d.acc   = acc_new;
                        s_d.upd   = upd_new;
                        s_d.do_wb = (mode_in == AM_PRE) || (mode_in == AM_POST);
                        s_d.sz    = dual ? SZ_WORD : size_in;
                        s_d.sgn   = sign & ~dual;
                        s_d.st    = is_store;
                        s_d.du    = dual;
                        s_d.d0    = st_data;
                        s_d.d1    = st_data2;
                    end
                end
            end
            PH_BEAT0: begin
                s_d.ph = s_q.du ? PH_BEAT1 : PH_FIN;
            end
            PH_BEAT1: begin
                s_d.ph = PH_FIN;
                if (!s_q.st) begin
                    s_d.rv  = 1'b1;
                    s_d.res = ext_res;
                end
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.wbe = s_q.do_wb;
                if (!s_q.st) begin
                    s_d.rv  = 1'b1;
                    s_d.r2  = s_q.du;
                    s_d.res = ext_res;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.ph != PH_IDLE);
    assign illegal   = s_q.bad;
    assign mem_req   = (s_q.ph == PH_BEAT0) || (s_q.ph == PH_BEAT1);
    assign mem_we    = mem_req & s_q.st;
    assign mem_addr  = (s_q.ph == PH_BEAT1) ? (s_q.acc + BEAT_STEP) : s_q.acc;
    assign ld_valid  = s_q.rv;
    assign ld_second = s_q.r2;
    assign ld_data   = s_q.res;
    assign wb_en     = s_q.wbe;
    assign wb_val    = s_q.upd;
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          illegal,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_be,
    input logic          ld_valid,
    input logic          ld_second,
    input logic          wb_en
);
    p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_wb_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> !busy);

    p_wb_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en);

    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !mem_req && !wb_en && !ld_valid));

    p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                     mem_be == 4'b1100 || mem_be == 4'b1111));

    p_next_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + AW'(4)));

    p_second_has_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_second |-> ld_valid);
endmodule

bind ldst_unit ldst_unit_chk #(.AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .illegal   (illegal),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .ld_valid  (ld_valid),
    .ld_second (ld_second),
    .wb_en     (wb_en)
);

// File: tb/ldst_unit_test.sv
module ldst_unit_test;
    localparam int AW = 16;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base = '0;
    logic [OW-1:0] offset = '0;
    logic          sub = 1'b0;
    logic [1:0]    mode = '0;
    logic [1:0]    size = '0;
    logic          sign = 1'b0;
    logic          is_store = 1'b0;
    logic          dual = 1'b0;
    logic [31:0]   st_data = '0;
    logic [31:0]   st_data2 = '0;
    logic          busy, illegal, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;
    logic          ld_valid, ld_second, wb_en;
    logic [31:0]   ld_data;
    logic [AW-1:0] wb_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] ram [0:63];

    always #5 clk = ~clk;

    ldst_unit #(.ADDR_W(AW), .OFF_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .offset(offset),
        .sub(sub), .mode(mode), .size(size), .sign(sign), .is_store(is_store),
        .dual(dual), .st_data(st_data), .st_data2(st_data2), .busy(busy),
        .illegal(illegal), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_second(ld_second), .ld_data(ld_data),
        .wb_en(wb_en), .wb_val(wb_val)
    );

    always_ff @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) ram[mem_addr[7:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
            end
            mem_rdata <= ram[mem_addr[7:2]];
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'd0:    return 4'b0001 << a;
            2'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] ref_wd(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'd0:    return {4{d[7:0]}};
            2'd1:    return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] ref_ext(input logic [31:0] w, input logic [1:0] sz,
                                            input bit sg, input logic [1:0] a);
        logic [7:0]  b;
        logic [15:0] h;
        case (sz)
            2'd0: begin
                b = w[8*a +: 8];
                return sg ? {{24{b[7]}}, b} : {24'b0, b};
            end
            2'd1: begin
                h = a[1] ? w[31:16] : w[15:0];
                return sg ? {{16{h[15]}}, h} : {16'b0, h};
            end
            default: return w;
        endcase
    endfunction

    task automatic idle_chk(input string req);
        chk(req, "busy idle", 32'(busy), 0);
        chk(req, "mem_req idle", 32'(mem_req), 0);
        chk(req, "ld_valid idle", 32'(ld_valid), 0);
        chk(req, "wb_en idle", 32'(wb_en), 0);
        chk(req, "illegal idle", 32'(illegal), 0);
    endtask

    task automatic do_op(input string req, input logic [AW-1:0] b, input logic [OW-1:0] o,
                         input bit s, input logic [1:0] md, input logic [1:0] sz,
                         input bit sg, input bit st, input bit du,
                         input logic [31:0] d0, input logic [31:0] d1, input bit poke);
        logic [AW-1:0] upd, acc, acc2;
        logic [1:0]    esz;
        logic [31:0]   w0, w1;
        bit            wbe, bad;
        upd  = s ? (b - AW'(o)) : (b + AW'(o));
        acc  = (md == 2'd2) ? b : upd;
        acc2 = acc + AW'(4);
        wbe  = (md == 2'd1) || (md == 2'd2);
        bad  = (md == 2'd3) || (!du && (sz == 2'd3 || (sg && st && sz != 2'd2)));
        esz  = du ? 2'd2 : sz;
        w0 = '0;
        w1 = '0;

        @(negedge clk);
        base = b; offset = o; sub = s; mode = md; size = sz; sign = sg;
        is_store = st; dual = du; st_data = d0; st_data2 = d1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            chk(req, "illegal pulse", 32'(illegal), 1);
            chk(req, "no busy on illegal", 32'(busy), 0);
            chk(req, "no req on illegal", 32'(mem_req), 0);
            @(negedge clk);
            idle_chk(req);
            return;
        end
        chk(req, "illegal low", 32'(illegal), 0);
        chk(req, "busy beat0", 32'(busy), 1);
        chk(req, "req beat0", 32'(mem_req), 1);
        chk(req, "we beat0", 32'(mem_we), 32'(st));
        chk(req, "addr beat0", 32'(mem_addr), 32'(acc));
        chk(req, "be beat0", 32'(mem_be), 32'(ref_be(esz, acc[1:0])));
        if (st) chk(req, "wdata beat0", mem_wdata, ref_wd(esz, d0));
        chk(req, "no result beat0", 32'(ld_valid), 0);
        w0 = ram[acc[7:2]];
        if (poke) begin
            is_store = ~st; dual = ~du; mode = 2'd1; base = ~b; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        if (du) begin
            chk(req, "req beat1", 32'(mem_req), 1);
            chk(req, "addr beat1", 32'(mem_addr), 32'(acc2));
            chk(req, "be beat1", 32'(mem_be), 32'hF);
            if (st) chk(req, "wdata beat1", mem_wdata, d1);
            chk(req, "no result beat1", 32'(ld_valid), 0);
            w1 = ram[acc2[7:2]];
            @(negedge clk);
            chk(req, "req done", 32'(mem_req), 0);
            chk(req, "busy fin", 32'(busy), 1);
            chk(req, "first result valid", 32'(ld_valid), 32'(!st));
            chk(req, "wb not early", 32'(wb_en), 0);
            if (!st) begin
                chk(req, "first result tag", 32'(ld_second), 0);
                chk(req, "first result data", ld_data, w0);
            end
        end else begin
            chk(req, "req done", 32'(mem_req), 0);
            chk(req, "busy fin", 32'(busy), 1);
            chk(req, "no early result", 32'(ld_valid), 0);
        end
        @(negedge clk);
        chk(req, "busy cleared", 32'(busy), 0);
        chk(req, "req idle", 32'(mem_req), 0);
        chk(req, "final result valid", 32'(ld_valid), 32'(!st));
        if (!st) begin
            chk(req, "final result tag", 32'(ld_second), 32'(du));
            chk(req, "final result data", ld_data, du ? w1 : ref_ext(w0, sz, sg, acc[1:0]));
        end
        chk(req, "wb_en", 32'(wb_en), 32'(wbe));
        if (wbe) chk(req, "wb_val", 32'(wb_val), 32'(upd));
        @(negedge clk);
        idle_chk(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) ram[i] = '0;
        repeat (3) @(negedge clk);
        idle_chk("R12");
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R12");

        do_op("R2", 16'h0010, 8'd4, 0, 2'd0, 2'd2, 0, 1, 0, 32'h8A7F_C3E5, 0, 0);
        do_op("R1", 16'h0014, 8'd0, 0, 2'd0, 2'd2, 0, 0, 0, 0, 0, 0);
        do_op("R7", 16'h0014, 8'd1, 0, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0);
        do_op("R7", 16'h0018, 8'd2, 1, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0);
        do_op("R7", 16'h0015, 8'd0, 0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0);
        do_op("R7", 16'h0016, 8'd0, 0, 2'd0, 2'd1, 1, 0, 0, 0, 0, 0);
        do_op("R7", 16'h0014, 8'd0, 0, 2'd0, 2'd1, 0, 0, 0, 0, 0, 0);
        do_op("R7", 16'h0014, 8'd0, 0, 2'd0, 2'd1, 1, 0, 0, 0, 0, 0);

        do_op("R3", 16'h0020, 8'd2, 0, 2'd1, 2'd1, 0, 1, 0, 32'h1234_F00D, 0, 0);
        do_op("R6", 16'h0020, 8'd0, 0, 2'd0, 2'd2, 0, 0, 0, 0, 0, 0);
        do_op("R4", 16'h0031, 8'd3, 1, 2'd2, 2'd0, 0, 1, 0, 32'h0000_00A5, 0, 0);
        do_op("R5", 16'h0030, 8'd0, 0, 2'd0, 2'd2, 0, 0, 0, 0, 0, 0);
        do_op("R5", 16'h0033, 8'd0, 0, 2'd1, 2'd0, 0, 1, 0, 32'h0000_005C, 0, 0);
        do_op("R6", 16'h0030, 8'd0, 0, 2'd0, 2'd2, 0, 0, 0, 0, 0, 0);

        do_op("R9", 16'h0040, 8'd8, 0, 2'd1, 2'd0, 0, 1, 1, 32'hCAFE_0001, 32'hBEEF_0002, 0);
        do_op("R9", 16'h0048, 8'd8, 1, 2'd2, 2'd1, 1, 0, 1, 0, 0, 0);

        do_op("R1", 16'hFFFC, 8'd8, 0, 2'd2, 2'd2, 0, 1, 0, 32'h5555_AAAA, 0, 0);
        do_op("R1", 16'h0004, 8'd8, 1, 2'd1, 2'd2, 0, 0, 0, 0, 0, 0);

        do_op("R8", 16'h0010, 8'd0, 0, 2'd0, 2'd0, 1, 1, 0, 32'hFFFF_FFFF, 0, 0);
        do_op("R8", 16'h0010, 8'd0, 0, 2'd3, 2'd2, 0, 0, 0, 0, 0, 0);
        do_op("R8", 16'h0010, 8'd0, 0, 2'd0, 2'd3, 0, 1, 0, 0, 0, 0);
        do_op("R2", 16'h0010, 8'd4, 0, 2'd0, 2'd2, 0, 0, 0, 0, 0, 0);

        do_op("R11", 16'h0014, 8'd0, 0, 2'd0, 2'd2, 0, 0, 0, 0, 0, 1);
        do_op("R10", 16'h0014, 8'd0, 0, 2'd0, 2'd2, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule